// File: doc/BRIEF.md
# Multi-Lane Channel Bonding Deskew

This block takes several receive lanes, four by default, each delivering one decoded 8-bit symbol plus a control-character flag per clock. It lines the lanes up so that symbols sent together on the far side leave the block in the same cycle. Lane 0 acts as the master. Every lane writes into its own circular buffer at a shared write pointer. Each lane reads from that buffer through its own read pointer. The master's read pointer always trails the write pointer by a fixed hold distance.

A per-lane matcher looks for a programmable bonding sequence. The sequence holds up to eight symbols, and each symbol has a value, a control flag and a don't-care flag. When the master matches, a bounded search window opens. Each slave must have matched no more than the window length before the master, or must match no more than that many cycles after it. When the window closes with every slave found, each slave read pointer is reloaded so that its sequence leaves together with the master's, and the bonded status rises.

A pending clock-correction event can veto the start of a bonding attempt while arbitration is enabled. An optional one-shot mode allows only one attempt for each time bonding is enabled.

Top module: `lane_deskew`

## Requirements
- R1: After reset, `bonded` is 0 and all output lanes are zero. A symbol sampled on lane 0 at clock edge n appears on the lane 0 output just after edge n+HOLD (HOLD defaults to 64). Bonding never changes this latency.
- R2: A lane matches when its last SEQ_LEN symbols equal the sequence. Symbol i (i = 0 is the oldest) is compared on its 8-bit value (bits 8i+7..8i of SEQ_VAL) and on its control flag (bit i of SEQ_K), unless bit i of SEQ_DC marks it don't-care. Positions at or above SEQ_LEN are ignored. A symbol whose value matches but whose control flag is wrong produces no match.
- R3: For a bonding attempt to succeed, each slave's match must fall no more than WIN cycles (default 31) before or after the master's match. Both bounds are inclusive.
- R4: When an attempt succeeds, the window closes at edge m+WIN, where m is the master's match edge. From edge m+WIN+1 onward, every slave output is shifted by its match distance, so the sequence symbols of all lanes leave in the same cycle.
- R5: `bonded` is set at window close when every slave was found and cleared when any slave was missing. It is also cleared in the cycle after `bond_en` is sampled low.
- R6: After a failed attempt, the next master match starts a new attempt. A master match while a window is already open starts nothing.
- R7: With `one_shot` high, only the first master match after `bond_en` rises starts an attempt. Later sequences change neither `bonded` nor any lane alignment until `bond_en` falls again.
- R8: A master match in a cycle where both `arb_en` and `cc_pending` are high starts no attempt. With `arb_en` low, `cc_pending` has no effect.
- R9: A failed attempt leaves every read pointer where it was. Only slave read pointers are ever reloaded, so master data is never skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bond_en | input | 1 | Enables bonding; low clears the status and re-arms one-shot mode |
| one_shot | input | 1 | Allows a single attempt per enable |
| arb_en | input | 1 | Lets clock correction veto a bonding start |
| cc_pending | input | 1 | A clock-correction event is pending |
| rx_data | input | LANES*8 | Received symbols, lane l in bits 8l+7..8l |
| rx_k | input | LANES | Control-character flag per lane |
| tx_data | output | LANES*8 | Deskewed symbols, same lane packing |
| tx_k | output | LANES | Deskewed control flags |
| bonded | output | 1 | All lanes aligned by the last completed attempt |

## Verification
A master sequence match can arrive in the same cycle that a clock-correction event is pending. The bench provokes this by holding `cc_pending` high across a whole injected sequence burst, first with `arb_en` high and then with it low. It judges the outcome by whether `bonded` and the per-lane output alignment keep their previous values or take on the new skews. The second collision is a one-shot attempt already spent when a fresh sequence arrives whose skew would fail. Here `bonded` must stay high and the alignment must stay unchanged.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;
  localparam int SYM_W = 9;

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } sym_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_OPEN = 1'b1} bond_state_t;
endpackage

// File: rtl/lane_deskew_match.sv
module lane_deskew_match
  import lane_deskew_pkg::*;
#(
  parameter int          SEQ_LEN = 1,
  parameter logic [63:0] SEQ_VAL = 64'h7C,
  parameter logic [7:0]  SEQ_K   = 8'h01,
  parameter logic [7:0]  SEQ_DC  = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  sym_t sym_in,
  output logic hit
);
  localparam int HW = SYM_W * SEQ_LEN;

  // win_v[9k +: 9] holds the symbol seen k cycles ago (k = 0 is the current one)
  logic [HW-1:0] win_v;

  generate
    if (SEQ_LEN > 1) begin : g_hist
      logic [HW-SYM_W-1:0] hist_q;
      assign win_v = {hist_q, sym_in};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= win_v[HW-SYM_W-1:0];
      end
    end else begin : g_single
      assign win_v = sym_in;
    end
  endgenerate

  function automatic logic sym_equal(logic [SYM_W-1:0] s, int i);
    return (s[8] == SEQ_K[i]) && (s[7:0] == SEQ_VAL[8*i +: 8]);
  endfunction

  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (!SEQ_DC[i] && !sym_equal(win_v[SYM_W*(SEQ_LEN-1-i) +: SYM_W], i)) hit = 1'b0;
    end
  end
endmodule

// File: rtl/lane_deskew_buf.sv
module lane_deskew_buf
  import lane_deskew_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int HOLD  = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] wr_ptr,
  input  sym_t          wr_sym,
  input  logic          load,
  input  logic [AW-1:0] load_ptr,
  output sym_t          rd_sym
);
  sym_t          mem [DEPTH];
  logic [AW-1:0] rd_ptr;

  always_ff @(posedge clk) mem[wr_ptr] <= wr_sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= AW'(DEPTH - HOLD);
      rd_sym <= '0;
    end else begin
      rd_ptr <= load ? load_ptr : rd_ptr + AW'(1);
      rd_sym <= mem[rd_ptr];
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> rd_ptr == $past(rd_ptr) + AW'(1)); // R9
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rd_ptr == $past(load_ptr)); // R4
endmodule

// File: rtl/lane_deskew_ctrl.sv
module lane_deskew_ctrl
  import lane_deskew_pkg::*;
#(
  parameter int LANES = 4,
  parameter int HOLD  = 64,
  parameter int WIN   = 31,
  parameter int AW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bond_en,
  input  logic              one_shot,
  input  logic              arb_en,
  input  logic              cc_pending,
  input  logic [LANES-1:0]  hit,
  input  logic [AW-1:0]     wr_ptr,
  output logic [LANES-1:0]  load,
  output logic [LANES*AW-1:0] load_ptr,
  output logic              bonded
);
  localparam int CW = $clog2(WIN + 1);

  bond_state_t   state;
  logic [CW-1:0] win_cnt;
  logic [AW-1:0] mpos;
  logic          used;

  logic          seen    [1:LANES-1];
  logic [CW-1:0] age     [1:LANES-1];
  logic [AW-1:0] lpos    [1:LANES-1];
  logic [AW-1:0] fpos    [1:LANES-1];
  logic [AW-1:0] fpos_n  [1:LANES-1];
  logic [LANES-1:1] found, found_n, start_ok;

  logic start, last_slot, all_ok, commit;

  // slave read pointer that lines its match up with the master's
  function automatic logic [AW-1:0] slip_ptr(logic [AW-1:0] wr, logic [AW-1:0] f, logic [AW-1:0] m);
    return wr + AW'(1) - AW'(HOLD) + f - m;
  endfunction

  function automatic logic [AW-1:0] skew_dist(logic [AW-1:0] a, logic [AW-1:0] b);
    logic [AW-1:0] d1, d2;
    d1 = a - b;
    d2 = b - a;
    return (d1 < d2) ? d1 : d2;
  endfunction

  assign start = bond_en && (state == ST_IDLE) && hit[0]
              && !(one_shot && used) && !(arb_en && cc_pending);
  assign last_slot = (state == ST_OPEN) && (win_cnt == CW'(WIN - 1));

  always_comb begin
    for (int l = 1; l < LANES; l++) begin
      start_ok[l] = hit[l] || (seen[l] && (age[l] < CW'(WIN)));
      found_n[l]  = found[l] || hit[l];
      fpos_n[l]   = found[l] ? fpos[l] : wr_ptr;
    end
  end

  assign all_ok = &found_n;
  assign commit = bond_en && last_slot && all_ok;

  always_comb begin
    load     = '0;
    load_ptr = '0;
    for (int l = 1; l < LANES; l++) begin
      load[l]               = commit;
      load_ptr[l*AW +: AW]  = slip_ptr(wr_ptr, fpos_n[l], mpos);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      win_cnt <= '0;
      mpos    <= '0;
      used    <= 1'b0;
      bonded  <= 1'b0;
      found   <= '0;
      for (int l = 1; l < LANES; l++) begin
        seen[l] <= 1'b0;
        age[l]  <= '0;
        lpos[l] <= '0;
        fpos[l] <= '0;
      end
    end else begin
      for (int l = 1; l < LANES; l++) begin
        if (hit[l]) begin
          seen[l] <= 1'b1;
          age[l]  <= '0;
          lpos[l] <= wr_ptr;
        end else if (age[l] != CW'(WIN)) begin
          age[l] <= age[l] + CW'(1);
        end
      end
      if (!bond_en) begin
        state  <= ST_IDLE;
        bonded <= 1'b0;
        used   <= 1'b0;
      end else if (state == ST_IDLE) begin
        if (start) begin
          state   <= ST_OPEN;
          win_cnt <= '0;
          mpos    <= wr_ptr;
          used    <= 1'b1;
          found   <= start_ok;
          for (int l = 1; l < LANES; l++) fpos[l] <= hit[l] ? wr_ptr : lpos[l];
        end
      end else begin
        found <= found_n;
        for (int l = 1; l < LANES; l++) fpos[l] <= fpos_n[l];
        if (last_slot) begin
          state  <= ST_IDLE;
          bonded <= all_ok;
        end else begin
          win_cnt <= win_cnt + CW'(1);
        end
      end
    end
  end

  AST_BOND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !bond_en |=> !bonded); // R5
  AST_CC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && arb_en && cc_pending) |=> state == ST_IDLE); // R8
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bond_en && one_shot && used && state == ST_IDLE) |=> $stable(bonded)); // R7

  generate
    for (genvar g = 1; g < LANES; g++) begin : g_skew_chk
      AST_SKEW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> skew_dist(fpos_n[g], mpos) <= AW'(WIN)); // R3
    end
  endgenerate
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import lane_deskew_pkg::*;
#(
  parameter int          LANES   = 4,
  parameter int          DEPTH   = 128,
  parameter int          HOLD    = 64,
  parameter int          WIN     = 31,
  parameter int          SEQ_LEN = 1,
  parameter logic [63:0] SEQ_VAL = 64'h7C,
  parameter logic [7:0]  SEQ_K   = 8'h01,
  parameter logic [7:0]  SEQ_DC  = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bond_en,
  input  logic               one_shot,
  input  logic               arb_en,
  input  logic               cc_pending,
  input  logic [LANES*8-1:0] rx_data,
  input  logic [LANES-1:0]   rx_k,
  output logic [LANES*8-1:0] tx_data,
  output logic [LANES-1:0]   tx_k,
  output logic               bonded
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]       wr_ptr;
  logic [LANES-1:0]    hit;
  logic [LANES-1:0]    load;
  logic [LANES*AW-1:0] load_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= wr_ptr + AW'(1);
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      sym_t in_sym, out_sym;
      assign in_sym = '{k: rx_k[g], d: rx_data[8*g +: 8]};

      lane_deskew_match #(
        .SEQ_LEN(SEQ_LEN), .SEQ_VAL(SEQ_VAL), .SEQ_K(SEQ_K), .SEQ_DC(SEQ_DC)
      ) u_match (
        .clk(clk), .rst_n(rst_n), .sym_in(in_sym), .hit(hit[g])
      );

      lane_deskew_buf #(.DEPTH(DEPTH), .HOLD(HOLD), .AW(AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .wr_sym(in_sym),
        .load(load[g]), .load_ptr(load_ptr[g*AW +: AW]), .rd_sym(out_sym)
      );

      assign tx_data[8*g +: 8] = out_sym.d;
      assign tx_k[g]           = out_sym.k;
    end
  endgenerate

  lane_deskew_ctrl #(.LANES(LANES), .HOLD(HOLD), .WIN(WIN), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bond_en(bond_en), .one_shot(one_shot),
    .arb_en(arb_en), .cc_pending(cc_pending), .hit(hit), .wr_ptr(wr_ptr),
    .load(load), .load_ptr(load_ptr), .bonded(bonded)
  );
endmodule

// File: tb/lane_deskew_test.sv
`timescale 1ns/100ps
module lane_deskew_test;
  localparam int          L    = 4;
  localparam int          HOLD = 64;
  localparam int          W    = 31;
  localparam int          SL   = 2;
  localparam logic [63:0] SVAL = 64'h7C;
  localparam logic [7:0]  SK   = 8'h01;
  localparam logic [7:0]  SDC  = 8'h02;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bond_en = 1'b0, one_shot = 1'b0, arb_en = 1'b0, cc_pending = 1'b0;
  logic [L*8-1:0] rx_data = '0, tx_data;
  logic [L-1:0]   rx_k = '0, tx_k;
  logic           bonded;

  always #2.5 clk = ~clk;

  lane_deskew #(.LANES(L), .DEPTH(128), .HOLD(HOLD), .WIN(W),
    .SEQ_LEN(SL), .SEQ_VAL(SVAL), .SEQ_K(SK), .SEQ_DC(SDC)) uut (
    .clk(clk), .rst_n(rst_n), .bond_en(bond_en), .one_shot(one_shot),
    .arb_en(arb_en), .cc_pending(cc_pending), .rx_data(rx_data), .rx_k(rx_k),
    .tx_data(tx_data), .tx_k(tx_k), .bonded(bonded));

  int n_chk = 0, n_fail = 0;
  int e = 0;
  int hd [L][4096];
  bit hk [L][4096];
  int inj [L];
  bit mk = 1'b1, want_align = 1'b0;
  // reference model state
  int lastdet [L];
  int fpos [L];
  int off [L];
  bit found [L];
  bit st = 0, used_m = 0, bond_m = 0;
  int ms = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, e, act, exp);
    end
  endtask

  function automatic bit mhit(int l, int t);
    for (int i = 0; i < SL; i++) begin
      if (!SDC[i]) begin
        int tt = t - (SL - 1 - i);
        if (tt < 0) return 0;
        if (hd[l][tt] != int'(SVAL[8*i +: 8]) || hk[l][tt] != SK[i]) return 0;
      end
    end
    return 1;
  endfunction

  // drive inputs for edge e, wait for it, then check and advance the model
  task automatic cycle();
    bit hit [L];
    for (int l = 0; l < L; l++) begin
      if (e == inj[l]) begin
        hd[l][e] = 8'h7C;
        hk[l][e] = (l == 0) ? mk : 1'b1;
      end else begin
        hd[l][e] = (e * 37 + l * 11 + 5) & 8'hFF;
        hk[l][e] = 1'b0;
      end
      rx_data[8*l +: 8] = hd[l][e][7:0];
      rx_k[l]           = hk[l][e];
    end
    @(posedge clk);
    #1;
    for (int l = 0; l < L; l++) begin
      int idx = e - HOLD + off[l];
      if (e >= HOLD && idx >= 0) begin
        int act = {tx_k[l], tx_data[8*l +: 8]};
        int exp = {hk[l][idx], hd[l][idx][7:0]};
        if (l == 0) chk(act == exp, "R1 master lane", act, exp);
        else        chk(act == exp, "R4 R9 slave lane", act, exp);
      end
    end
    if (want_align && e == inj[0] + HOLD) begin
      for (int l = 0; l < L; l++)
        chk({tx_k[l], tx_data[8*l +: 8]} == 9'h17C, "R4 sequences leave together",
            {tx_k[l], tx_data[8*l +: 8]}, 9'h17C);
    end
    for (int l = 0; l < L; l++) hit[l] = mhit(l, e);
    if (!bond_en) begin
      st = 0; bond_m = 0; used_m = 0;
    end else if (!st) begin
      if (hit[0] && !(one_shot && used_m) && !(arb_en && cc_pending)) begin
        st = 1; ms = e; used_m = 1;
        for (int l = 1; l < L; l++) begin
          found[l] = hit[l] || (lastdet[l] >= 0 && e - lastdet[l] <= W);
          fpos[l]  = hit[l] ? e : lastdet[l];
        end
      end
    end else begin
      for (int l = 1; l < L; l++)
        if (!found[l] && hit[l]) begin found[l] = 1; fpos[l] = e; end
      if (e - ms == W) begin
        bit all = 1;
        st = 0;
        for (int l = 1; l < L; l++) all &= found[l];
        bond_m = all;
        if (all) for (int l = 1; l < L; l++) off[l] = fpos[l] - ms;
      end
    end
    for (int l = 0; l < L; l++) if (hit[l]) lastdet[l] = e;
    chk(bonded == bond_m, "R5 bonded status", bonded, bond_m);
    e++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic burst(int s1, int s2, int s3, bit align);
    inj[0] = e + 40;
    inj[1] = inj[0] + s1;
    inj[2] = inj[0] + s2;
    inj[3] = inj[0] + s3;
    want_align = align;
    run(130);
    want_align = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at edge %0d: actual hung expected done", e);
    finish_up();
  end

  initial begin
    for (int l = 0; l < L; l++) begin lastdet[l] = -1000; off[l] = 0; inj[l] = -1; end
    repeat (3) @(posedge clk);
    #1;
    chk(bonded == 1'b0, "R1 reset bonded", bonded, 0);
    chk(tx_data == '0 && tx_k == '0, "R1 reset outputs", tx_data, 0);
    rst_n = 1'b1;
    bond_en = 1'b1;
    run(100);
    // skewed lanes inside the window
    burst(3, -5, 0, 1'b1);
    chk(bonded == 1'b1, "R4 bond with mixed skew", bonded, 1);
    // slave outside the window: failure, pointers kept
    burst(40, 0, 0, 1'b0);
    chk(bonded == 1'b0, "R3 skew of 40 rejected", bonded, 0);
    // retry at the inclusive window edges
    burst(31, -31, 2, 1'b1);
    chk(bonded == 1'b1, "R3 R6 retry at window edges", bonded, 1);
    // clock correction wins while arbitration is on
    arb_en = 1'b1; cc_pending = 1'b1;
    burst(5, 5, 5, 1'b0);
    chk(bonded == 1'b1, "R8 attempt vetoed", bonded, 1);
    arb_en = 1'b0;
    burst(-7, 4, 9, 1'b1);
    chk(bonded == 1'b1, "R8 no veto without arbitration", bonded, 1);
    cc_pending = 1'b0;
    // disable clears status
    bond_en = 1'b0;
    run(2);
    chk(bonded == 1'b0, "R5 cleared by disable", bonded, 0);
    bond_en = 1'b1;
    // master symbol without control flag is not a match
    mk = 1'b0;
    burst(1, 1, 1, 1'b0);
    chk(bonded == 1'b0, "R2 flag mismatch gives no match", bonded, 0);
    mk = 1'b1;
    // one-shot
    bond_en = 1'b0;
    run(2);
    one_shot = 1'b1; bond_en = 1'b1;
    burst(2, 2, 2, 1'b1);
    chk(bonded == 1'b1, "R7 first attempt bonds", bonded, 1);
    burst(40, 0, 0, 1'b0);
    chk(bonded == 1'b1, "R7 later sequence ignored", bonded, 1);
    finish_up();
  end
endmodule